// File: doc/BRIEF.md
# Backlight Level Duty Converter

This block converts between an 8-bit brightness request and the 16-bit active duty count of a backlight pulse-width modulator. The PWM period register and a period bit count are set at run time. On the forward path, the level is first stretched to a U1.16 fraction so that full scale maps to exactly 1.0. That fraction is then multiplied by the masked period, and the product is reduced to a top-aligned 16-bit duty word with rounding. The forward result is registered and appears one cycle after the request.

The reverse path runs the other way. It takes a duty word, the period and the bit count, and returns a normalised brightness. This path needs a true division, so it uses a sequential restoring divider driven by a three-state machine. `RB_IDLE` moves to `RB_DIVIDE` when a request is accepted. `RB_DIVIDE` stays for one cycle per quotient bit and moves to `RB_FINISH` when its bit counter reaches zero. `RB_FINISH` applies the halving round and the scale-back multiply, fires the done strobe and returns to `RB_IDLE`.

At acceptance, the reverse path captures the duty, the fractional flag, the masked period and the effective bit count. The forward path stays free while a readback runs. The PWM generator and any register access sit outside the block.

Top module: `bl_duty_conv`

## Requirements
- R1: The level L expands to the 17-bit fraction U = {L, L} + L[7]. This equals the upper 16 bits of L*0x10101, plus bit 7 of that 24-bit product as rounding. So level 0 gives 0 and level 0xFF gives 0x10000.
- R2: The effective bit count N is 16 when `bitcnt` is 0, and `bitcnt` otherwise. The period used is `period` masked to its low N bits, so with `bitcnt`=0 and level 0xFF the duty equals `period`.
- R3: Let P = U * masked period. The forward duty is (P >> N) plus bit N-1 of P. Any value above 0xFFFF is clamped to 0xFFFF.
- R4: `duty_valid` is high exactly in the cycle after `fwd_req` is sampled high, and `duty_out` changes only then. Reset clears both outputs to 0.
- R5: On readback with `frac_en`=0, the duty is ANDed with the N-bit mask shifted into the top N bits of the 16-bit word. With `frac_en`=1, all 16 bits are used.
- R6: On readback, a masked period of 0 is used as 0xFFFF.
- R7: Readback computes Q = (D << (N+1)) / p and then Q' = (Q+1) >> 1. It then forms M = Q' * p, and the result is (M >> N) plus bit N-1 of M, on 17 bits.
- R8: `rb_valid` pulses for one cycle 34 cycles after the edge that accepts `rb_req`. `rb_busy` is high from the next cycle until the cycle before `rb_valid`. Reset clears `rb_busy` and `rb_valid`.
- R9: An `rb_req` that arrives while `rb_busy` is high is ignored. The running result is not disturbed and no extra `rb_valid` follows.
- R10: A readback uses the duty, flag, period and bit count present at acceptance. Forward requests and input changes during the run affect neither its result nor the forward results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fwd_req | input | 1 | Start a forward conversion |
| level | input | 8 | Brightness request |
| period | input | 16 | PWM period register value |
| bitcnt | input | 4 | Period bit count, 0 means 16 |
| rb_req | input | 1 | Start a readback |
| rb_duty | input | 16 | Duty word to read back |
| frac_en | input | 1 | Keep all 16 duty bits on readback |
| duty_out | output | 16 | Forward duty count |
| duty_valid | output | 1 | Forward result strobe |
| rb_busy | output | 1 | Readback in progress |
| rb_valid | output | 1 | Readback result strobe |
| rb_level | output | 17 | Normalised brightness from readback |

## Verification
The bench aims at the points where the arithmetic is easiest to get subtly wrong:
- Level 0x80 and level 0xFF test the expansion rounding; dropping bit 7 moves the duty by one count.
- A period carrying bits above the bit count shows a missing mask as an inflated duty.
- Bit count 1 exercises the N-1 rounding index at its lowest position.
- A masked period of zero would otherwise divide by zero.
- The fractional flag is run on a duty with low bits set; a swapped mask selection changes the readback value.
- A second request during a busy readback, together with input changes and forward requests, exposes a divider that restarts, reloads its operands or pulses twice.

// File: rtl/bl_duty_pkg.sv
package bl_duty_pkg;

    // Readback sequencer states
    typedef enum logic [1:0] {
        RB_IDLE   = 2'd0,
        RB_DIVIDE = 2'd1,
        RB_FINISH = 2'd2
    } rb_state_t;

endpackage

// File: rtl/bl_period_mask.sv
// Effective bit count and period mask, shared by both conversion paths.
module bl_period_mask #(
    parameter  int PER_W = 16,
    localparam int BC_W  = $clog2(PER_W)
) (
    input  logic [BC_W-1:0]  bitcnt,
    input  logic [PER_W-1:0] period,
    output logic [BC_W:0]    eff,
    output logic [PER_W-1:0] mask,
    output logic [PER_W-1:0] mper
);

    assign eff = (bitcnt == '0) ? (BC_W+1)'(PER_W) : {1'b0, bitcnt};

    for (genvar i = 0; i < PER_W; i++) begin : g_mask
        assign mask[i] = ((BC_W+1)'(i) < eff);
    end

    assign mper = period & mask;

endmodule

// File: rtl/bl_level_expand.sv
// Stretches a half-width level to a U1.PER_W fraction (x * 256/255 for 8 bits).
module bl_level_expand #(
    parameter  int PER_W = 16,
    localparam int LVL_W = PER_W / 2
) (
    input  logic [LVL_W-1:0] level,
    output logic [PER_W:0]   frac_q
);

    // {L,L,L} equals L*0x10101; its top PER_W bits are {L,L} and bit LVL_W-1 is L's MSB.
    assign frac_q = {1'b0, level, level} + (PER_W+1)'(level[LVL_W-1]);

endmodule

// File: rtl/bl_fwd_scale.sv
// Scales the fraction by the masked period and reduces to a rounded duty word.
module bl_fwd_scale #(
    parameter  int PER_W = 16,
    localparam int BC_W  = $clog2(PER_W)
) (
    input  logic [PER_W:0]   frac_q,
    input  logic [PER_W-1:0] mper,
    input  logic [BC_W:0]    eff,
    output logic [PER_W-1:0] duty
);

    localparam int PROD_W = 2 * PER_W + 1;

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] prod_sh;
    logic              rnd;
    logic [PER_W:0]    sum;
    logic              over;

    always_comb begin
        prod    = PROD_W'(frac_q) * PROD_W'(mper);
        prod_sh = prod >> eff;
        rnd     = prod[eff - 1'b1];
        sum     = {1'b0, prod_sh[PER_W-1:0]} + (PER_W+1)'(rnd);
        over    = (|prod_sh[PROD_W-1:PER_W]) | sum[PER_W];
        duty    = over ? '1 : sum[PER_W-1:0];
    end

endmodule

// File: rtl/bl_rb_divider.sv
// Readback path: restoring divider plus round and scale-back, under a small FSM.
module bl_rb_divider
    import bl_duty_pkg::*;
#(
    parameter  int PER_W = 16,
    localparam int BC_W  = $clog2(PER_W),
    localparam int RB_W  = PER_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [PER_W-1:0] duty_in,
    input  logic             frac_en,
    input  logic [PER_W-1:0] mask,
    input  logic [PER_W-1:0] mper,
    input  logic [BC_W:0]    eff,
    output logic             busy,
    output logic             done,
    output logic [RB_W-1:0]  level_out
);

    localparam int NUM_W = 2 * PER_W + 1;
    localparam int MUL_W = NUM_W + PER_W;
    localparam int CNT_W = $clog2(NUM_W);

    rb_state_t state_q, state_d;

    logic [NUM_W-1:0] num_q;
    logic [NUM_W-1:0] quo_q;
    logic [PER_W-1:0] rem_q;
    logic [PER_W-1:0] den_q;
    logic [BC_W:0]    eff_q;
    logic [CNT_W-1:0] cnt_q;
    logic [RB_W-1:0]  level_q;
    logic             done_q;

    // operand setup
    logic [PER_W-1:0] top_mask;
    logic [PER_W-1:0] dsel;
    logic [NUM_W-1:0] num_init;
    logic [PER_W-1:0] den_init;
    // one divide step
    logic [PER_W:0]   trial;
    logic             ge;
    logic [PER_W-1:0] diff;
    // finish step
    logic [NUM_W-1:0] q_half;
    logic [MUL_W-1:0] back;
    logic [MUL_W-1:0] back_sh;
    logic             rnd;
    logic [RB_W:0]    sum;
    logic [RB_W-1:0]  res;

    always_comb begin
        top_mask = mask << ((BC_W+1)'(PER_W) - eff);
        dsel     = frac_en ? duty_in : (duty_in & top_mask);
        num_init = NUM_W'(dsel) << (eff + 1'b1);
        den_init = (mper == '0) ? '1 : mper;

        trial = {rem_q, num_q[NUM_W-1]};
        ge    = (trial >= {1'b0, den_q});
        diff  = trial[PER_W-1:0] - den_q;

        q_half  = {1'b0, quo_q[NUM_W-1:1]} + NUM_W'(quo_q[0]);
        back    = MUL_W'(q_half) * MUL_W'(den_q);
        back_sh = back >> eff_q;
        rnd     = back[eff_q - 1'b1];
        sum     = {1'b0, back_sh[RB_W-1:0]} + (RB_W+1)'(rnd);
        res     = ((|back_sh[MUL_W-1:RB_W]) | sum[RB_W]) ? '1 : sum[RB_W-1:0];
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RB_IDLE:   if (start) state_d = RB_DIVIDE;
            RB_DIVIDE: if (cnt_q == '0) state_d = RB_FINISH;
            RB_FINISH: state_d = RB_IDLE;
            default:   state_d = RB_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RB_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            num_q   <= '0;
            quo_q   <= '0;
            rem_q   <= '0;
            den_q   <= '1;
            eff_q   <= (BC_W+1)'(PER_W);
            cnt_q   <= '0;
            level_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                RB_IDLE: begin
                    if (start) begin
                        num_q <= num_init;
                        quo_q <= '0;
                        rem_q <= '0;
                        den_q <= den_init;
                        eff_q <= eff;
                        cnt_q <= CNT_W'(NUM_W - 1);
                    end
                end
                RB_DIVIDE: begin
                    num_q <= num_q << 1;
                    quo_q <= {quo_q[NUM_W-2:0], ge};
                    rem_q <= ge ? diff : trial[PER_W-1:0];
                    cnt_q <= cnt_q - CNT_W'(1);
                end
                RB_FINISH: begin
                    level_q <= res;
                    done_q  <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy      = (state_q != RB_IDLE);
    assign done      = done_q;
    assign level_out = level_q;

endmodule

// File: rtl/bl_duty_conv.sv
module bl_duty_conv #(
    parameter  int PER_W = 16,
    localparam int LVL_W = PER_W / 2,
    localparam int BC_W  = $clog2(PER_W),
    localparam int RB_W  = PER_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fwd_req,
    input  logic [LVL_W-1:0] level,
    input  logic [PER_W-1:0] period,
    input  logic [BC_W-1:0]  bitcnt,
    input  logic             rb_req,
    input  logic [PER_W-1:0] rb_duty,
    input  logic             frac_en,
    output logic [PER_W-1:0] duty_out,
    output logic             duty_valid,
    output logic             rb_busy,
    output logic             rb_valid,
    output logic [RB_W-1:0]  rb_level
);

    logic [BC_W:0]    eff;
    logic [PER_W-1:0] mask;
    logic [PER_W-1:0] mper;
    logic [PER_W:0]   frac_q;
    logic [PER_W-1:0] fwd_duty;
    logic [PER_W-1:0] duty_q;
    logic             dvalid_q;

    bl_period_mask #(.PER_W(PER_W)) u_mask (
        .bitcnt (bitcnt),
        .period (period),
        .eff    (eff),
        .mask   (mask),
        .mper   (mper)
    );

    bl_level_expand #(.PER_W(PER_W)) u_expand (
        .level  (level),
        .frac_q (frac_q)
    );

    bl_fwd_scale #(.PER_W(PER_W)) u_scale (
        .frac_q (frac_q),
        .mper   (mper),
        .eff    (eff),
        .duty   (fwd_duty)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_q   <= '0;
            dvalid_q <= 1'b0;
        end else begin
            dvalid_q <= fwd_req;
            if (fwd_req) duty_q <= fwd_duty;
        end
    end

    assign duty_out   = duty_q;
    assign duty_valid = dvalid_q;

    bl_rb_divider #(.PER_W(PER_W)) u_rb (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (rb_req),
        .duty_in   (rb_duty),
        .frac_en   (frac_en),
        .mask      (mask),
        .mper      (mper),
        .eff       (eff),
        .busy      (rb_busy),
        .done      (rb_valid),
        .level_out (rb_level)
    );

endmodule

// File: rtl/bl_duty_conv_chk.sv
module bl_duty_conv_chk #(
    parameter  int PER_W = 16,
    localparam int LVL_W = PER_W / 2,
    localparam int BC_W  = $clog2(PER_W),
    localparam int RB_W  = PER_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fwd_req,
    input logic [LVL_W-1:0] level,
    input logic [PER_W-1:0] period,
    input logic [BC_W-1:0]  bitcnt,
    input logic             rb_req,
    input logic [PER_W-1:0] duty_out,
    input logic             duty_valid,
    input logic             rb_busy,
    input logic             rb_valid,
    input logic [RB_W-1:0]  rb_level
);

    localparam int LAT   = 2 * PER_W + 2;
    localparam int LCW   = $clog2(LAT + 2);

    logic [LCW-1:0] lat_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)                 lat_cnt <= '0;
        else if (rb_req && !rb_busy) lat_cnt <= '0;
        else if (rb_busy)            lat_cnt <= lat_cnt + LCW'(1);
    end

    AST_FWD_STROBE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_req |=> duty_valid);  // R4
    AST_FWD_STROBE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !fwd_req |=> !duty_valid);  // R4
    AST_FWD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fwd_req |=> $stable(duty_out));  // R4
    AST_ZERO_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_req && level == '0) |=> (duty_out == '0));  // R1
    AST_FULL_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_req && level == '1 && bitcnt == '0) |=> (duty_out == $past(period)));  // R2
    AST_RB_START: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_req && !rb_busy) |=> rb_busy);  // R8
    AST_RB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        rb_valid |-> !rb_busy);  // R8
    AST_RB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rb_valid |=> !rb_valid);  // R9
    AST_RB_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rb_valid |-> (lat_cnt == LCW'(LAT)));  // R8

    logic unused_ok;
    assign unused_ok = ^rb_level;

endmodule

bind bl_duty_conv bl_duty_conv_chk #(.PER_W(PER_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fwd_req    (fwd_req),
    .level      (level),
    .period     (period),
    .bitcnt     (bitcnt),
    .rb_req     (rb_req),
    .duty_out   (duty_out),
    .duty_valid (duty_valid),
    .rb_busy    (rb_busy),
    .rb_valid   (rb_valid),
    .rb_level   (rb_level)
);

// File: tb/bl_duty_conv_test.sv
`timescale 1ns/1ps
module bl_duty_conv_test;

    localparam int LAT = 34;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fwd_req = 1'b0;
    logic [7:0]  level = '0;
    logic [15:0] period = '0;
    logic [3:0]  bitcnt = '0;
    logic        rb_req = 1'b0;
    logic [15:0] rb_duty = '0;
    logic        frac_en = 1'b0;
    logic [15:0] duty_out;
    logic        duty_valid;
    logic        rb_busy;
    logic        rb_valid;
    logic [16:0] rb_level;

    int checks = 0;
    int errors = 0;
    string cur_tag = "R4";
    string rb_tag = "R8";

    always #4 clk = ~clk;

    bl_duty_conv uut (
        .clk(clk), .rst_n(rst_n), .fwd_req(fwd_req), .level(level),
        .period(period), .bitcnt(bitcnt), .rb_req(rb_req), .rb_duty(rb_duty),
        .frac_en(frac_en), .duty_out(duty_out), .duty_valid(duty_valid),
        .rb_busy(rb_busy), .rb_valid(rb_valid), .rb_level(rb_level)
    );

    function automatic longint fwd_ref(longint lvl, longint per, int bc);
        longint e24, u, mp, pr, v;
        int b;
        e24 = lvl * 64'h10101;
        u   = (e24 >> 8) + ((e24 >> 7) & 1);
        b   = (bc == 0) ? 16 : bc;
        mp  = per & ((64'd1 << b) - 1);
        pr  = u * mp;
        v   = (pr >> b) + ((pr >> (b - 1)) & 1);
        if (v > 65535) v = 65535;
        return v;
    endfunction

    function automatic longint rb_ref(longint d, longint per, int bc, bit frac);
        longint pm, p, tm, dd, num, q, m, r;
        int b;
        b  = (bc == 0) ? 16 : bc;
        pm = (64'd1 << b) - 1;
        p  = per & pm;
        tm = (pm << (16 - b)) & 64'hFFFF;
        dd = frac ? (d & 64'hFFFF) : (d & tm);
        if (p == 0) p = 65535;
        num = dd << (1 + b);
        q   = num / p;
        q   = (q + 1) >> 1;
        m   = q * p;
        r   = (m >> b) + ((m >> (b - 1)) & 1);
        if (r > 64'h1FFFF) r = 64'h1FFFF;
        return r;
    endfunction

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // behavioural reference, advanced at each edge, compared 2 ns later
    bit     e_dv = 0, e_rv = 0;
    longint e_duty = 0, e_rbl = 0, rb_pend = 0;
    int     rb_cnt = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            e_dv = 0; e_rv = 0; e_duty = 0; e_rbl = 0; rb_cnt = 0;
        end else begin
            e_dv = fwd_req;
            if (fwd_req) e_duty = fwd_ref(level, period, bitcnt);
            e_rv = 0;
            if (rb_cnt == 0) begin
                if (rb_req) begin
                    rb_cnt  = LAT;
                    rb_pend = rb_ref(rb_duty, period, bitcnt, frac_en);
                    rb_tag  = cur_tag;
                end
            end else begin
                rb_cnt--;
                if (rb_cnt == 0) begin
                    e_rv  = 1;
                    e_rbl = rb_pend;
                end
            end
        end
        #2;
        if (!rst_n) begin
            check(duty_valid == 0 && duty_out == 0, "R4", "reset forward outputs", duty_out, 0);
            check(rb_busy == 0 && rb_valid == 0, "R8", "reset readback strobes", {rb_busy, rb_valid}, 0);
        end else begin
            check(duty_valid == e_dv, "R4", "duty_valid", duty_valid, e_dv);
            if (e_dv) check(duty_out == e_duty[15:0], cur_tag, "duty_out", duty_out, e_duty);
            check(rb_busy == (rb_cnt > 0), "R8", "rb_busy", rb_busy, rb_cnt > 0);
            check(rb_valid == e_rv, rb_tag == "R9" ? "R9" : "R8", "rb_valid", rb_valid, e_rv);
            if (e_rv) check(rb_level == e_rbl[16:0], rb_tag, "rb_level", rb_level, e_rbl);
        end
    end

    task automatic fwd(logic [7:0] l, logic [15:0] p, logic [3:0] b, string tag);
        @(negedge clk);
        cur_tag = tag; level = l; period = p; bitcnt = b; fwd_req = 1'b1;
        @(negedge clk);
        fwd_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic rb(logic [15:0] d, logic [15:0] p, logic [3:0] b, bit f, string tag);
        @(negedge clk);
        cur_tag = tag; rb_duty = d; period = p; bitcnt = b; frac_en = f; rb_req = 1'b1;
        @(negedge clk);
        rb_req = 1'b0;
        repeat (LAT + 2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 expansion: zero, rounding bit set, full scale
        fwd(8'h00, 16'hFFFF, 4'd0, "R1");
        fwd(8'h80, 16'hFFFF, 4'd0, "R1");
        fwd(8'h7F, 16'hFFFF, 4'd0, "R1");
        fwd(8'hFF, 16'hFFFF, 4'd0, "R1");
        // R2 bit count decode and period masking
        fwd(8'hFF, 16'h1234, 4'd0, "R2");
        fwd(8'hEF, 16'hFFE4, 4'd6, "R2");
        fwd(8'hA5, 16'hFFFF, 4'd15, "R2");
        fwd(8'hC3, 16'hFFFF, 4'd1, "R2");
        // R3 product, shift, round over a spread of inputs
        fwd(8'hEF, 16'h0024, 4'd6, "R3");
        for (int i = 0; i < 16; i++)
            fwd(8'(i * 17), 16'(16'h0FA0 + i * 16'h0731), 4'(i), "R3");
        // R5 duty selection by the fractional flag
        rb(16'h86F7, 16'h0024, 4'd6, 1'b0, "R5");
        rb(16'h86F7, 16'h0024, 4'd6, 1'b1, "R5");
        // R6 masked period of zero
        rb(16'h4000, 16'h0040, 4'd6, 1'b0, "R6");
        rb(16'h1234, 16'h0000, 4'd0, 1'b1, "R6");
        // R7 arithmetic
        rb(16'h8000, 16'hFFFF, 4'd0, 1'b0, "R7");
        rb(16'h1234, 16'h03FF, 4'd10, 1'b1, "R7");
        rb(16'hFFFF, 16'h0001, 4'd1, 1'b0, "R7");
        rb(16'h0FA0, 16'h0FA0, 4'd12, 1'b0, "R7");
        // R9 second request while busy is ignored
        @(negedge clk);
        cur_tag = "R9"; rb_duty = 16'hC000; period = 16'h00FF; bitcnt = 4'd8; frac_en = 1'b0; rb_req = 1'b1;
        @(negedge clk);
        rb_req = 1'b0;
        repeat (5) @(negedge clk);
        rb_duty = 16'h1111; period = 16'h0003; rb_req = 1'b1;
        repeat (3) @(negedge clk);
        rb_req = 1'b0;
        repeat (LAT + 4) @(negedge clk);
        // R10 forward traffic and input changes during a readback
        @(negedge clk);
        cur_tag = "R10"; rb_duty = 16'h5A5A; period = 16'h7FFF; bitcnt = 4'd15; frac_en = 1'b1; rb_req = 1'b1;
        @(negedge clk);
        rb_req = 1'b0;
        fwd(8'h33, 16'h0123, 4'd9, "R10");
        fwd(8'hFE, 16'hFFFF, 4'd0, "R10");
        rb_duty = 16'h0001; frac_en = 1'b0;
        repeat (LAT + 2) @(negedge clk);
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule